// File: doc/BRIEF.md
# Serial Port Status and Clock-Select Register

This block holds the CPU-visible status word of a serial communication port and the small control field that picks its clock source. The transmit and receive engines report events as one-cycle pulses: transmit buffer empty, receive buffer full, overrun, framing error, parity error, transmission complete, and a received multiprocessor bit. The block latches each event into a flag. Five of the flags are sticky. The CPU clears a sticky flag by first reading it as 1 and then writing 0 to that bit position. A blind write of 0 leaves the flag set. This stops software from clearing an event it has never seen.

The transmission-complete flag and the received multiprocessor bit are driven only by hardware, and CPU writes to them are ignored. The lowest status bit is an ordinary read/write bit that holds the multiprocessor bit for the next transmission. A second register address holds a 2-bit clock-select field. Together with the synchronous or asynchronous mode input, this field sets the role of the serial clock pin: general I/O, bit-rate clock output, serial clock output, external clock input, or an illegal setting that is flagged. Entering any low-power mode returns the status word to its reset value.

Top module: `sci_status_reg`

## Requirements
- R1: After a synchronous active-low reset, the status word is 0x84. Bit layout from MSB to LSB: tx-empty(7), rx-full(6), overrun(5), framing(4), parity(3), tx-done(2), rx-mpb(1), tx-mpb(0).
- R2: While `lowpwr` is high, the status word is loaded with 0x84 on every clock, all read-as-1 arms are dropped, and event pulses are ignored. A later write of 0 does not clear flags that were read before the low-power entry.
- R3: Each bit of `flag_set` sets one sticky flag on the next clock: bit 4 sets status bit 7, bit 3 sets bit 6, bit 2 sets bit 5, bit 1 sets bit 4, and bit 0 sets bit 3.
- R4: A sticky flag clears on a status write with a 0 in its position only if a status read has returned it as 1 since it was last set. A status write of 0 without such a read leaves it at 1.
- R5: Writing 1 to a sticky flag position never changes the flag and does not cancel its arm.
- R6: A hardware set of a flag that is already 1 cancels its arm. A new read is needed before a clear takes effect.
- R7: When a set pulse and a valid clearing write hit the same flag in one cycle, the flag stays 1.
- R8: Status bits 2 and 1 ignore CPU writes. Bit 2 follows `tend_set` and `tend_clr`, with set taking priority. Bit 1 loads `mpb_value` when `mpb_load` is high.
- R9: Status bit 0 takes `bus_wdata[0]` on every status write, and `mpbt_o` reflects it.
- R10: The clock-select field is written and read at `bus_wdata[2:1]`/`bus_rdata[2:1]` of the control address, with the other control bits reading 0. In asynchronous mode, 00 leaves the pin as general I/O (`sck_gpio`=1), 01 drives a bit-rate clock out (`sck_oe`=`sck_clk_en`=1), and 10 selects an external clock at 16x the bit rate (`clk_ext`=`clk_ext_x16`=1).
- R11: In synchronous mode, 00 drives the serial clock out (`sck_oe`=`sck_clk_en`=1) and 10 takes the serial clock in (`clk_ext`=1, `clk_ext_x16`=0).
- R12: Asynchronous 11, and synchronous 01 or 11, raise `cfg_err` and hold `sck_oe`, `sck_clk_en`, `sck_gpio`, `clk_ext` and `clk_ext_x16` at 0.
- R13: `bus_rdata` is combinational. It shows the status word when `bus_sel` and `bus_rd` are high at the status address, shows the control view at the control address, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| flag_set | input | 5 | Set pulses for the sticky flags |
| tend_set | input | 1 | Transmission-complete set pulse |
| tend_clr | input | 1 | Transmission-complete clear pulse |
| mpb_load | input | 1 | Load strobe for the received multiprocessor bit |
| mpb_value | input | 1 | Received multiprocessor bit value |
| sync_mode | input | 1 | 1 = synchronous, 0 = asynchronous |
| lowpwr | input | 1 | Standby, module-standby or watch mode active |
| status_o | output | 8 | Status word |
| mpbt_o | output | 1 | Multiprocessor bit to transmit |
| sck_oe | output | 1 | Block drives the serial clock pin |
| sck_clk_en | output | 1 | Internal clock placed on the pin |
| sck_gpio | output | 1 | Pin left to general I/O |
| clk_ext | output | 1 | External clock selected |
| clk_ext_x16 | output | 1 | External clock runs at 16x the bit rate |
| cfg_err | output | 1 | Reserved clock-select setting |

## Verification
The bench builds the block with a 2-bit address and places the status and control registers at addresses 2 and 3. This moves them off the default decode. Reads of the unused address 0 must then return 0, which shows that the address compare uses the parameters and not fixed values. On every clock a behavioural model checks the whole status word, the read bus and the pin-role outputs. Directed sequences cover blind clears, set-during-clear collisions, arm cancellation by a repeated event, low-power entry with pending arms, and all eight mode/clock-select combinations.

// File: rtl/sci_stat_pkg.sv
// Package: shared constants and types for the serial status register.
// Assumes an 8-bit status word whose bit order is decoded by neighbours.
package sci_stat_pkg;

    localparam int unsigned STAT_W     = 8;
    localparam int unsigned NUM_STICKY = 5;
    localparam int unsigned STICKY_LSB = 3;
    localparam int unsigned BIT_TDONE  = 2;
    localparam int unsigned BIT_MPBR   = 1;
    localparam int unsigned BIT_MPBT   = 0;
    localparam int unsigned CKS_W      = 2;
    localparam int unsigned CKS_LSB    = 1;
    localparam logic [STAT_W-1:0] STAT_RESET = 8'h84;

    typedef enum logic [CKS_W-1:0] {
        CKS_INT_PLAIN = 2'b00,
        CKS_INT_ALT   = 2'b01,
        CKS_EXT       = 2'b10,
        CKS_RSVD      = 2'b11
    } cks_e;

    typedef struct packed {
        logic sck_oe;
        logic sck_clk_en;
        logic sck_gpio;
        logic clk_ext;
        logic clk_ext_x16;
        logic cfg_err;
    } sck_cfg_t;

endpackage

// File: rtl/sci_reg_decode.sv
// Module: turns the bus select, address and strobes into per-register
// read and write enables. Assumes the two addresses differ.
module sci_reg_decode #(
    parameter int unsigned ADDR_W      = 1,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 1
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              st_rd,
    output logic              st_wr,
    output logic              ctl_rd,
    output logic              ctl_wr
);

    logic hit_st;
    logic hit_ctl;

    // Address match for each register.
    always_comb begin
        hit_st  = sel && (addr == STATUS_ADDR);
        hit_ctl = sel && (addr == CTRL_ADDR);
    end

    // Qualify the matches with the strobes.
    always_comb begin
        st_rd  = hit_st  && rd;
        st_wr  = hit_st  && wr;
        ctl_rd = hit_ctl && rd;
        ctl_wr = hit_ctl && wr;
    end

endmodule

// File: rtl/sci_flag_cell.sv
// Module: one sticky status flag together with its read-as-1 arm.
// Priority, highest first: low-power restore, hardware set, armed clear,
// arming read. Assumes clr_i is a status write carrying 0 in this bit.
module sci_flag_cell #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lowpwr,
    input  logic set_i,
    input  logic clr_i,
    input  logic rd_i,
    output logic flag_o,
    output logic arm_o
);

    logic flag_q;
    logic arm_q;

    // Update the flag and its arm in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n || lowpwr) begin
            flag_q <= INIT;
            arm_q  <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
            arm_q  <= 1'b0;
        end else if (clr_i && arm_q) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else if (rd_i && flag_q) begin
            arm_q  <= 1'b1;
        end
    end

    assign flag_o = flag_q;
    assign arm_o  = arm_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !lowpwr) |=> flag_o); // R7
    AST_NO_BLIND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !arm_o && !lowpwr) |=> flag_o); // R4
    AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        arm_o |-> flag_o); // R4

endmodule

// File: rtl/sci_cks_decode.sv
// Module: maps the clock-select field and the mode input to the role of
// the serial clock pin. Purely combinational; reserved codes leave the pin
// undriven and raise an error.
module sci_cks_decode
    import sci_stat_pkg::*;
(
    input  logic [CKS_W-1:0] cks,
    input  logic             sync_mode,
    output sck_cfg_t         cfg
);

    // Decode the mode/select pair into the pin role.
    always_comb begin
        cfg = '0;
        unique case ({sync_mode, cks})
            {1'b0, CKS_INT_PLAIN}: cfg.sck_gpio = 1'b1;
            {1'b0, CKS_INT_ALT}: begin
                cfg.sck_oe     = 1'b1;
                cfg.sck_clk_en = 1'b1;
            end
            {1'b0, CKS_EXT}: begin
                cfg.clk_ext     = 1'b1;
                cfg.clk_ext_x16 = 1'b1;
            end
            {1'b1, CKS_INT_PLAIN}: begin
                cfg.sck_oe     = 1'b1;
                cfg.sck_clk_en = 1'b1;
            end
            {1'b1, CKS_EXT}: cfg.clk_ext = 1'b1;
            default: cfg.cfg_err = 1'b1;
        endcase
    end

endmodule

// File: rtl/sci_status_reg.sv
// Module: status word and clock-select register of a serial port.
// Sticky flags clear only after being read as 1; tx-done and rx-mpb are
// hardware-owned; low-power entry restores the status reset value. The
// clock-select field survives low power and is reset only by rst_n.
module sci_status_reg
    import sci_stat_pkg::*;
#(
    parameter int unsigned ADDR_W      = 1,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [STAT_W-1:0]     bus_wdata,
    output logic [STAT_W-1:0]     bus_rdata,
    input  logic [NUM_STICKY-1:0] flag_set,
    input  logic                  tend_set,
    input  logic                  tend_clr,
    input  logic                  mpb_load,
    input  logic                  mpb_value,
    input  logic                  sync_mode,
    input  logic                  lowpwr,
    output logic [STAT_W-1:0]     status_o,
    output logic                  mpbt_o,
    output logic                  sck_oe,
    output logic                  sck_clk_en,
    output logic                  sck_gpio,
    output logic                  clk_ext,
    output logic                  clk_ext_x16,
    output logic                  cfg_err
);

    logic st_rd, st_wr, ctl_rd, ctl_wr;
    logic [NUM_STICKY-1:0] sticky;
    logic [NUM_STICKY-1:0] arm_unused_view;
    logic tdone_q, mpbr_q, mpbt_q;
    logic [CKS_W-1:0] cks_q;
    logic [STAT_W-1:0] ctrl_view;
    sck_cfg_t cfg;

    sci_reg_decode #(
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR),
        .CTRL_ADDR   (CTRL_ADDR)
    ) u_dec (
        .sel    (bus_sel),
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .st_rd  (st_rd),
        .st_wr  (st_wr),
        .ctl_rd (ctl_rd),
        .ctl_wr (ctl_wr)
    );

    // One flag cell per sticky status bit; the reset value picks the init.
    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
        localparam int unsigned POS = STICKY_LSB + i;
        sci_flag_cell #(
            .INIT (STAT_RESET[POS])
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .lowpwr (lowpwr),
            .set_i  (flag_set[i]),
            .clr_i  (st_wr && !bus_wdata[POS]),
            .rd_i   (st_rd),
            .flag_o (sticky[i]),
            .arm_o  (arm_unused_view[i])
        );
    end

    // Hardware-owned tx-done flag; set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n || lowpwr)  tdone_q <= STAT_RESET[BIT_TDONE];
        else if (tend_set)     tdone_q <= 1'b1;
        else if (tend_clr)     tdone_q <= 1'b0;
    end

    // Hardware-owned received multiprocessor bit.
    always_ff @(posedge clk) begin
        if (!rst_n || lowpwr)  mpbr_q <= STAT_RESET[BIT_MPBR];
        else if (mpb_load)     mpbr_q <= mpb_value;
    end

    // CPU-owned multiprocessor bit for transmission.
    always_ff @(posedge clk) begin
        if (!rst_n || lowpwr)  mpbt_q <= STAT_RESET[BIT_MPBT];
        else if (st_wr)        mpbt_q <= bus_wdata[BIT_MPBT];
    end

    // Clock-select field, kept through low power.
    always_ff @(posedge clk) begin
        if (!rst_n)            cks_q <= CKS_INT_PLAIN;
        else if (ctl_wr)       cks_q <= bus_wdata[CKS_LSB +: CKS_W];
    end

    // Assemble the status word and the control read view.
    always_comb begin
        status_o = '0;
        status_o[STICKY_LSB +: NUM_STICKY] = sticky;
        status_o[BIT_TDONE] = tdone_q;
        status_o[BIT_MPBR]  = mpbr_q;
        status_o[BIT_MPBT]  = mpbt_q;
        ctrl_view = '0;
        ctrl_view[CKS_LSB +: CKS_W] = cks_q;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (st_rd)       bus_rdata = status_o;
        else if (ctl_rd) bus_rdata = ctrl_view;
    end

    sci_cks_decode u_cks (
        .cks       (cks_q),
        .sync_mode (sync_mode),
        .cfg       (cfg)
    );

    assign mpbt_o      = mpbt_q;
    assign sck_oe      = cfg.sck_oe;
    assign sck_clk_en  = cfg.sck_clk_en;
    assign sck_gpio    = cfg.sck_gpio;
    assign clk_ext     = cfg.clk_ext;
    assign clk_ext_x16 = cfg.clk_ext_x16;
    assign cfg_err     = cfg.cfg_err;

    AST_LOWPWR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr |=> (status_o == STAT_RESET)); // R2
    AST_TDONE_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !tend_set && !tend_clr && !lowpwr) |=> $stable(status_o[BIT_TDONE])); // R8
    AST_MPBR_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (!mpb_load && !lowpwr) |=> $stable(status_o[BIT_MPBR])); // R8
    AST_MPBT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !lowpwr) |=> (mpbt_o == $past(bus_wdata[BIT_MPBT]))); // R9
    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!sck_oe && !sck_clk_en && !clk_ext)); // R12
    AST_ONE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sck_gpio, sck_oe, clk_ext, cfg_err})); // R10

endmodule

// File: tb/tb_sci_status_reg.sv
// Bench: behavioural reference model compared every clock, plus directed
// checks with hand-computed expected values.
module tb_sci_status_reg;

    localparam logic [1:0] A_ST  = 2'd2;
    localparam logic [1:0] A_CTL = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 0, bus_rd = 0, bus_wr = 0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] flag_set = '0;
    logic tend_set = 0, tend_clr = 0, mpb_load = 0, mpb_value = 0;
    logic sync_mode = 0, lowpwr = 0;
    logic [7:0] status_o;
    logic mpbt_o, sck_oe, sck_clk_en, sck_gpio, clk_ext, clk_ext_x16, cfg_err;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sci_status_reg #(.ADDR_W(2), .STATUS_ADDR(A_ST), .CTRL_ADDR(A_CTL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .flag_set(flag_set), .tend_set(tend_set),
        .tend_clr(tend_clr), .mpb_load(mpb_load), .mpb_value(mpb_value),
        .sync_mode(sync_mode), .lowpwr(lowpwr), .status_o(status_o),
        .mpbt_o(mpbt_o), .sck_oe(sck_oe), .sck_clk_en(sck_clk_en),
        .sck_gpio(sck_gpio), .clk_ext(clk_ext), .clk_ext_x16(clk_ext_x16),
        .cfg_err(cfg_err)
    );

    // ---- reference model ----
    int m_st = 8'h84;
    int m_arm[8];
    int m_cks = 0;

    function automatic int pins_exp(int cks, bit syn);
        // packing: {oe, clk_en, gpio, ext, x16, err}
        if (!syn && cks == 0) return 6'b001000;
        if (!syn && cks == 1) return 6'b110000;
        if (!syn && cks == 2) return 6'b000110;
        if (syn && cks == 0)  return 6'b110000;
        if (syn && cks == 2)  return 6'b000100;
        return 6'b000001;
    endfunction

    function automatic int rdata_exp();
        if (!bus_sel || !bus_rd) return 0;
        if (bus_addr == A_ST)  return m_st;
        if (bus_addr == A_CTL) return m_cks * 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        int nxt;
        bit wst, rst;
        if (!rst_n || lowpwr) begin
            m_st = 8'h84;
            foreach (m_arm[k]) m_arm[k] = 0;
            if (!rst_n) m_cks = 0;
        end else begin
            wst = bus_sel && bus_wr && bus_addr == A_ST;
            rst = bus_sel && bus_rd && bus_addr == A_ST;
            nxt = m_st;
            for (int b = 3; b < 8; b++) begin
                if (flag_set[b-3]) begin
                    nxt = nxt | (1 << b); m_arm[b] = 0;
                end else if (wst && !bus_wdata[b] && m_arm[b] != 0) begin
                    nxt = nxt & ~(1 << b); m_arm[b] = 0;
                end else if (rst && ((m_st >> b) & 1) != 0) begin
                    m_arm[b] = 1;
                end
            end
            if (tend_set) nxt = nxt | 4;
            else if (tend_clr) nxt = nxt & ~4;
            if (mpb_load) nxt = mpb_value ? (nxt | 2) : (nxt & ~2);
            if (wst) nxt = bus_wdata[0] ? (nxt | 1) : (nxt & ~1);
            m_st = nxt;
            if (bus_sel && bus_wr && bus_addr == A_CTL) m_cks = int'(bus_wdata[2:1]);
        end
        started = 1;
    end

    function automatic int pins_act();
        return {26'd0, sck_oe, sck_clk_en, sck_gpio, clk_ext, clk_ext_x16, cfg_err};
    endfunction

    // Per-clock comparison against the model, away from the edge.
    always @(posedge clk) begin
        #5;
        if (started && !done) begin
            checks++;
            if (int'(status_o) != m_st) begin
                errors++;
                $display("FAIL R4 model status actual=%02h expected=%02h", status_o, m_st);
            end
            checks++;
            if (pins_act() != pins_exp(m_cks, sync_mode)) begin
                errors++;
                $display("FAIL R10 model pins actual=%06b expected=%06b", pins_act(), pins_exp(m_cks, sync_mode));
            end
            checks++;
            if (int'(bus_rdata) != rdata_exp()) begin
                errors++;
                $display("FAIL R13 model rdata actual=%02h expected=%02h", bus_rdata, rdata_exp());
            end
        end
    end

    // ---- directed helpers ----
    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_sel = 0; bus_rd = 0; bus_wr = 0; bus_wdata = '0; bus_addr = '0;
        flag_set = '0; tend_set = 0; tend_clr = 0; mpb_load = 0; mpb_value = 0;
        lowpwr = 0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic rd(logic [1:0] a, output int v);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #5 v = int'(bus_rdata);
        @(negedge clk);
        idle();
    endtask

    task automatic pulse(logic [4:0] s);
        @(negedge clk);
        flag_set = s;
        @(negedge clk);
        idle();
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset status", status_o, 8'h84);
        chk("R10 reset pins async gpio", pins_act(), 6'b001000);

        pulse(5'b01000);
        chk("R3 rx-full set", status_o, 8'hC4);
        wr(A_ST, 8'h00);
        chk("R4 blind write ignored", status_o, 8'hC4);
        rd(A_ST, v);
        chk("R13 status read", v, 8'hC4);
        wr(A_ST, 8'hBF);
        chk("R4 R5 armed clear, write 1 kept", status_o, 8'h85);
        chk("R9 mpbt out", mpbt_o, 1);
        wr(A_ST, 8'h7F);
        chk("R5 arm survives write of 1", status_o, 8'h05);

        pulse(5'b00111);
        chk("R3 error flags set", status_o, 8'h3D);
        rd(A_ST, v);
        pulse(5'b00100);
        wr(A_ST, 8'h01);
        chk("R6 re-set cancels arm", status_o, 8'h25);

        rd(A_ST, v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = A_ST; bus_wdata = 8'h01; flag_set = 5'b00100;
        @(negedge clk);
        idle();
        chk("R7 set beats clear", status_o, 8'h25);
        wr(A_ST, 8'h01);
        chk("R7 arm dropped after collision", status_o, 8'h25);

        rd(A_ST, v);
        wr(A_ST, 8'h00);
        chk("R8 tx-done ignores write", status_o, 8'h04);
        @(negedge clk); tend_clr = 1; @(negedge clk); idle();
        chk("R8 tx-done cleared by hw", status_o, 8'h00);
        @(negedge clk); mpb_load = 1; mpb_value = 1; @(negedge clk); idle();
        chk("R8 rx-mpb loaded", status_o, 8'h02);
        @(negedge clk); tend_set = 1; tend_clr = 1; @(negedge clk); idle();
        wr(A_ST, 8'h00);
        chk("R8 read-only bits hold", status_o, 8'h06);

        pulse(5'b11000);
        wr(A_ST, 8'h01);
        chk("R9 mpbt written", status_o, 8'hC7);
        rd(A_ST, v);
        @(negedge clk); lowpwr = 1; flag_set = 5'b01000; @(negedge clk); idle();
        chk("R2 low power restores", status_o, 8'h84);
        wr(A_ST, 8'h00);
        chk("R2 arms lost in low power", status_o, 8'h84);

        wr(A_CTL, 8'h02);
        chk("R10 async 01 clock out", pins_act(), 6'b110000);
        rd(A_CTL, v);
        chk("R10 ctrl readback", v, 8'h02);
        wr(A_CTL, 8'h04);
        chk("R10 async ext x16", pins_act(), 6'b000110);
        wr(A_CTL, 8'hFF);
        chk("R12 async 11 reserved", pins_act(), 6'b000001);
        rd(A_CTL, v);
        chk("R10 ctrl other bits zero", v, 8'h06);
        @(negedge clk); sync_mode = 1;
        @(negedge clk);
        chk("R12 sync 11 reserved", pins_act(), 6'b000001);
        wr(A_CTL, 8'h00);
        chk("R11 sync clock out", pins_act(), 6'b110000);
        wr(A_CTL, 8'h02);
        chk("R12 sync 01 reserved", pins_act(), 6'b000001);
        wr(A_CTL, 8'h04);
        chk("R11 sync ext input", pins_act(), 6'b000100);

        rd(2'd0, v);
        chk("R13 unmapped address reads 0", v, 0);
        @(negedge clk); bus_rd = 1; bus_addr = A_ST; #5 v = int'(bus_rdata);
        @(negedge clk); idle();
        chk("R13 no select reads 0", v, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule